// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

This block turns one interrupt addressing request into a per-unit delivery bitmask for up to `N_UNITS` receiving units. Each unit has three configuration inputs: a physical ID byte, a logical-destination register whose top byte is the unit's logical address, and a destination-model register whose top nibble picks how that unit decodes logical addresses.

A request carries a destination byte, a physical/logical select, a two-bit shorthand code, the sender's physical ID and a lowest-priority flag. The shorthand code can replace normal addressing with "self", "everyone" or "everyone but self". When the lowest-priority flag is set, the result keeps only the lowest-numbered selected unit. The mask is computed combinationally and captured in a register. It appears with a one-cycle valid strobe on the clock after the request strobe. The registered mask holds its value until the next request.

Top module: `irq_dest_resolver`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `rsp_mask` is all zeros.
- R2: `rsp_valid` is high for exactly the cycle after each cycle in which `req_valid` is high. `rsp_mask` changes only on the clock edge that follows a request, and otherwise keeps its value even if the request inputs change.
- R3: With shorthand 0 and `req_logical`=0, a destination of 0xFF selects every unit.
- R4: With shorthand 0, `req_logical`=0 and a destination other than 0xFF, every unit whose physical ID equals the destination is selected. If no ID matches, the mask is zero.
- R5: With shorthand 0 and `req_logical`=1, a unit whose model nibble (bits 31:28 of its model register) is 0xF is selected when the destination AND its logical byte (bits 31:24 of its logical register) is nonzero.
- R6: With shorthand 0 and `req_logical`=1, a unit whose model nibble is 0x0 is selected when the upper nibbles of the destination and the logical byte are equal and the AND of their lower nibbles is nonzero.
- R7: In logical mode, a unit whose model nibble is neither 0x0 nor 0xF is never selected. Register bits other than the named fields have no effect.
- R8: Shorthand 1 selects only the units whose physical ID equals `req_sender_id`.
- R9: Shorthand 2 selects every unit.
- R10: Shorthand 3 selects every unit except those whose physical ID equals `req_sender_id`.
- R11: When `req_lowest`=1, only the lowest-numbered set bit of the mask built under R3 to R10 is kept. An empty mask stays empty.
- R12: With a nonzero shorthand, the destination byte and `req_logical` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_phys_id | input | N_UNITS*8 | Physical ID of each unit, unit i at bits 8i+7:8i |
| cfg_ldest_reg | input | N_UNITS*32 | Logical-destination register of each unit; logical byte at bits 31:24 |
| cfg_model_reg | input | N_UNITS*32 | Destination-model register of each unit; model nibble at bits 31:28 |
| req_valid | input | 1 | Request strobe |
| req_dest | input | 8 | Destination byte |
| req_logical | input | 1 | 0 = physical addressing, 1 = logical addressing |
| req_shorthand | input | 2 | 0 normal, 1 self, 2 all, 3 all but self |
| req_lowest | input | 1 | Lowest-priority delivery: keep the lowest set bit only |
| req_sender_id | input | 8 | Physical ID of the requesting unit |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_mask | output | N_UNITS | Registered delivery bitmask, bit i for unit i |

## Verification
The bench sets up a mix of flat units, cluster units and one unit with an invalid model nibble. It then picks destinations that separate the three matching rules. A cluster destination sharing low bits with flat units would expose a design that applied only one rule per request. A destination that hits the invalid-nibble unit's logical byte would expose a design that treated any non-0xF nibble as cluster. The physical tests cover an unmatched ID, and the shorthand tests use a destination that would select a different unit, so a design that merged the addressing paths with the shorthand would show wrong bits. The lowest-priority tests cover the "all but self" case where bit 0 is the sender, and an empty mask, which a faulty lowest-bit isolator would turn into a stray bit.

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver #(
  parameter int N_UNITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_UNITS*8-1:0]  cfg_phys_id,
  input  logic [N_UNITS*32-1:0] cfg_ldest_reg,
  input  logic [N_UNITS*32-1:0] cfg_model_reg,
  input  logic                 req_valid,
  input  logic [7:0]           req_dest,
  input  logic                 req_logical,
  input  logic [1:0]           req_shorthand,
  input  logic                 req_lowest,
  input  logic [7:0]           req_sender_id,
  output logic                 rsp_valid,
  output logic [N_UNITS-1:0]   rsp_mask
);
  localparam logic [7:0] BCAST = 8'hFF;
  localparam logic [3:0] MODEL_FLAT = 4'hF;
  localparam logic [3:0] MODEL_CLUSTER = 4'h0;

  logic [N_UNITS-1:0] phys_hit, logic_hit, self_hit, addr_mask, pre_mask, sel_mask;

  for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
    logic [7:0] pid, lbyte;
    logic [3:0] model;
    assign pid   = cfg_phys_id[i*8 +: 8];
    assign lbyte = cfg_ldest_reg[i*32+24 +: 8];
    assign model = cfg_model_reg[i*32+28 +: 4];
    assign phys_hit[i] = (req_dest == BCAST) || (pid == req_dest);
    assign self_hit[i] = (pid == req_sender_id);
    always_comb begin
      logic_hit[i] = 1'b0;
      if (model == MODEL_FLAT)
        logic_hit[i] = |(req_dest & lbyte);
      else if (model == MODEL_CLUSTER)
        logic_hit[i] = (req_dest[7:4] == lbyte[7:4]) && |(req_dest[3:0] & lbyte[3:0]);
    end
  end

  assign addr_mask = req_logical ? logic_hit : phys_hit;

  always_comb begin
    unique case (req_shorthand)
      2'd0: pre_mask = addr_mask;
      2'd1: pre_mask = self_hit;
      2'd2: pre_mask = '1;
      default: pre_mask = ~self_hit;
    endcase
  end

  assign sel_mask = req_lowest ? (pre_mask & (~pre_mask + 1'b1)) : pre_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_mask  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) rsp_mask <= sel_mask;
    end
  end
endmodule

// File: rtl/irq_dest_resolver_chk.sv
module irq_dest_resolver_chk #(
  parameter int N_UNITS = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [7:0]         req_dest,
  input logic               req_logical,
  input logic [1:0]         req_shorthand,
  input logic               req_lowest,
  input logic               rsp_valid,
  input logic [N_UNITS-1:0] rsp_mask
);
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(rsp_mask));
  p_phys_bcast_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_shorthand == 2'd0 && !req_logical && req_dest == 8'hFF && !req_lowest)
    |=> (&rsp_mask));
  p_all_units_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_shorthand == 2'd2 && !req_lowest) |=> (&rsp_mask));
  p_single_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_lowest) |=> $onehot0(rsp_mask));
  p_lowest_all_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_lowest && req_shorthand == 2'd2) |=> rsp_mask[0] && $onehot(rsp_mask));
endmodule

bind irq_dest_resolver irq_dest_resolver_chk #(.N_UNITS(N_UNITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dest(req_dest),
  .req_logical(req_logical), .req_shorthand(req_shorthand), .req_lowest(req_lowest),
  .rsp_valid(rsp_valid), .rsp_mask(rsp_mask)
);

// File: tb/tb_irq_dest_resolver.sv
module tb_irq_dest_resolver;
  localparam int N = 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N*8-1:0] cfg_phys_id;
  logic [N*32-1:0] cfg_ldest_reg, cfg_model_reg;
  logic req_valid = 1'b0, req_logical = 1'b0, req_lowest = 1'b0;
  logic [7:0] req_dest = 8'h00, req_sender_id = 8'h00;
  logic [1:0] req_shorthand = 2'd0;
  logic rsp_valid;
  logic [N-1:0] rsp_mask;
  int checks = 0, failures = 0;

  irq_dest_resolver #(.N_UNITS(N)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_phys_id(cfg_phys_id), .cfg_ldest_reg(cfg_ldest_reg),
    .cfg_model_reg(cfg_model_reg), .req_valid(req_valid), .req_dest(req_dest),
    .req_logical(req_logical), .req_shorthand(req_shorthand), .req_lowest(req_lowest),
    .req_sender_id(req_sender_id), .rsp_valid(rsp_valid), .rsp_mask(rsp_mask)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] dest, input logic lg, input logic [1:0] sh,
                      input logic lo, input logic [7:0] snd);
    @(negedge clk);
    req_dest = dest; req_logical = lg; req_shorthand = sh; req_lowest = lo;
    req_sender_id = snd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 valid", {31'd0, rsp_valid}, 32'd0);
    check("R1 mask", {24'd0, rsp_mask}, 32'd0);
  endtask

  task automatic t_physical;
    send(8'hFF, 1'b0, 2'd0, 1'b0, 8'h10);
    check("R2 valid", {31'd0, rsp_valid}, 32'd1);
    check("R3 broadcast", {24'd0, rsp_mask}, 32'hFF);
    send(8'h13, 1'b0, 2'd0, 1'b0, 8'h10);
    check("R4 id match", {24'd0, rsp_mask}, 32'h08);
    send(8'h42, 1'b0, 2'd0, 1'b0, 8'h10);
    check("R4 no match", {24'd0, rsp_mask}, 32'h00);
  endtask

  task automatic t_logical;
    send(8'h05, 1'b1, 2'd0, 1'b0, 8'h10);
    check("R5 flat", {24'd0, rsp_mask}, 32'h05);
    send(8'h23, 1'b1, 2'd0, 1'b0, 8'h10);
    check("R6 cluster", {24'd0, rsp_mask}, 32'h33);
    send(8'h30, 1'b1, 2'd0, 1'b0, 8'h10);
    check("R6 cluster low zero, R7 bad model", {24'd0, rsp_mask}, 32'h00);
    send(8'hFF, 1'b1, 2'd0, 1'b0, 8'h10);
    check("R7 bad model ignored", {24'd0, rsp_mask}, 32'h0F);
  endtask

  task automatic t_shorthand;
    send(8'h13, 1'b0, 2'd1, 1'b0, 8'h15);
    check("R8 self, R12", {24'd0, rsp_mask}, 32'h20);
    send(8'h13, 1'b1, 2'd2, 1'b0, 8'h15);
    check("R9 all, R12", {24'd0, rsp_mask}, 32'hFF);
    send(8'h15, 1'b0, 2'd3, 1'b0, 8'h15);
    check("R10 all but self, R12", {24'd0, rsp_mask}, 32'hDF);
  endtask

  task automatic t_lowest;
    send(8'h0C, 1'b1, 2'd0, 1'b1, 8'h10);
    check("R11 lowest of 0x0C", {24'd0, rsp_mask}, 32'h04);
    send(8'h00, 1'b0, 2'd3, 1'b1, 8'h10);
    check("R11 all but unit0", {24'd0, rsp_mask}, 32'h02);
    send(8'h42, 1'b0, 2'd0, 1'b1, 8'h10);
    check("R11 empty stays empty", {24'd0, rsp_mask}, 32'h00);
  endtask

  task automatic t_hold;
    send(8'h05, 1'b1, 2'd0, 1'b0, 8'h10);
    @(negedge clk);
    req_dest = 8'hFF; req_logical = 1'b0; req_shorthand = 2'd2;
    @(negedge clk);
    check("R2 valid drops", {31'd0, rsp_valid}, 32'd0);
    check("R2 mask holds", {24'd0, rsp_mask}, 32'h05);
  endtask

  initial begin
    for (int i = 0; i < N; i++) cfg_phys_id[i*8 +: 8] = 8'h10 + 8'(i);
    for (int i = 0; i < N; i++) begin
      cfg_ldest_reg[i*32 +: 32] = 32'h00FF_FFFF;
      cfg_model_reg[i*32 +: 32] = 32'h0FFF_FFFF;
    end
    cfg_ldest_reg[0*32+24 +: 8] = 8'h01; cfg_model_reg[0*32+28 +: 4] = 4'hF;
    cfg_ldest_reg[1*32+24 +: 8] = 8'h02; cfg_model_reg[1*32+28 +: 4] = 4'hF;
    cfg_ldest_reg[2*32+24 +: 8] = 8'h04; cfg_model_reg[2*32+28 +: 4] = 4'hF;
    cfg_ldest_reg[3*32+24 +: 8] = 8'h08; cfg_model_reg[3*32+28 +: 4] = 4'hF;
    cfg_ldest_reg[4*32+24 +: 8] = 8'h21; cfg_model_reg[4*32+28 +: 4] = 4'h0;
    cfg_ldest_reg[5*32+24 +: 8] = 8'h22; cfg_model_reg[5*32+28 +: 4] = 4'h0;
    cfg_ldest_reg[6*32+24 +: 8] = 8'h31; cfg_model_reg[6*32+28 +: 4] = 4'h0;
    cfg_ldest_reg[7*32+24 +: 8] = 8'hFF; cfg_model_reg[7*32+28 +: 4] = 4'h5;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_physical();
    t_logical();
    t_shorthand();
    t_lowest();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule